// File: doc/BRIEF.md
# Color Subcarrier Phase Generator

This block produces the running phase of the color subcarrier for an analog video encoder. Three accumulators are chained. A coarse 12-bit phase register advances by a programmable step on every active pixel. Two modular accumulators, each with its own programmable step and modulus, supply the fractional remainder. Each wrap of one stage injects one extra least-significant count into the stage above it. The subcarrier frequency is therefore an exact rational multiple of the pixel rate, not a truncated approximation.

The upper bits of the coarse register form the output phase word, which drives a sine lookup. That lookup, the burst envelope and the modulator all sit outside this block. So that the subcarrier phase pattern repeats with the field sequence, all three accumulators are cleared on a field-start strobe. The clear happens every second, fourth or eighth field, or never, as a 2-bit mode selects. Each stage has its own enable.

Top module: `sc_phase_gen`

## Requirements
- R1: After reset, `phase_out` is 0 and the internal field count is 0.
- R2: On an advancing cycle with the fine stage enabled, the fine accumulator adds `fine_inc`. If the sum is greater than or equal to `fine_mod`, the modulus is subtracted and one carry goes to the middle stage.
- R3: On an advancing cycle with the middle stage enabled, the middle accumulator adds `mid_inc` plus the fine carry. If the sum is greater than or equal to `mid_mod`, the modulus is subtracted and one carry goes to the coarse stage.
- R4: With the coarse stage enabled, the coarse register adds `coarse_inc` plus the middle carry, modulo 4096. `phase_out` is its upper PHASE_W bits.
- R5: A disabled stage holds its value and produces no carry. The stages above it still advance by their own step.
- R6: While `pix_en` is low and no clear occurs, all three accumulators hold.
- R7: `clr_mode` 0, 1 and 2 clear all accumulators on every 2nd, 4th and 8th `field_start` strobe respectively, counted from reset. A 3-bit counter counts every strobe, and the clear fires on the strobe that finds its low 1, 2 or 3 bits all ones.
- R8: `clr_mode` 3 never clears. Field strobes are still counted.
- R9: A clear takes precedence over a pixel advance in the same cycle, leaving all accumulators at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchronizer |
| pix_en | input | 1 | Advance accumulators this cycle |
| field_start | input | 1 | One-cycle strobe at the start of each field |
| clr_mode | input | 2 | 0: clear every 2 fields, 1: every 4, 2: every 8, 3: never |
| coarse_en | input | 1 | Enable of the 12-bit coarse phase stage |
| mid_en | input | 1 | Enable of the middle modular stage |
| fine_en | input | 1 | Enable of the fine modular stage |
| coarse_inc | input | 12 | Coarse phase step per pixel |
| mid_inc | input | 15 | Middle stage step |
| mid_mod | input | 15 | Middle stage modulus |
| fine_inc | input | 15 | Fine stage step |
| fine_mod | input | 15 | Fine stage modulus |
| phase_out | output | PHASE_W | Upper bits of the coarse phase |

## Verification
A fault in the fine or middle stage is not visible at once. It appears only when a missing or extra carry moves `phase_out` by one coarse count, which can take up to a full modulus period of pixels. Long runs are therefore compared cycle by cycle against an arithmetic model, and the middle and fine state is checked against a closed-form count after a fixed number of pixels. A wrong field count shows up as a phase that fails to return to zero, or returns to zero, on a specific strobe. It is therefore exercised in every clear mode across several strobe sequences.

// File: rtl/sc_phase_pkg.sv
package sc_phase_pkg;
  typedef enum logic [1:0] {
    CLR_EVERY2 = 2'd0,
    CLR_EVERY4 = 2'd1,
    CLR_EVERY8 = 2'd2,
    CLR_NEVER  = 2'd3
  } clr_mode_e;

  localparam int FCNT_W = 3;
endpackage

// File: rtl/sc_mod_dda.sv
module sc_mod_dda #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] inc,
  input  logic [W-1:0] modulus,
  input  logic         cin,
  output logic [W-1:0] acc,
  output logic         cout
);
  logic [W:0]   sum;
  logic [W:0]   wrapped;
  logic         wrap;
  logic [W-1:0] acc_n;

  always_comb begin
    sum     = {1'b0, acc} + {1'b0, inc} + {{W{1'b0}}, cin};
    wrap    = (sum >= {1'b0, modulus});
    wrapped = sum - {1'b0, modulus};
    acc_n   = acc;
    if (clr)
      acc_n = '0;
    else if (adv && en)
      acc_n = wrap ? wrapped[W-1:0] : sum[W-1:0];
    cout = adv && en && !clr && wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_n;
  end
endmodule

// File: rtl/sc_wrap_acc.sv
module sc_wrap_acc #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] inc,
  input  logic         cin,
  output logic [W-1:0] acc
);
  logic [W-1:0] acc_n;

  always_comb begin
    acc_n = acc;
    if (clr)
      acc_n = '0;
    else if (adv && en)
      acc_n = acc + inc + {{(W-1){1'b0}}, cin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_n;
  end
endmodule

// File: rtl/sc_field_sched.sv
module sc_field_sched
  import sc_phase_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_start,
  input  logic [1:0]        mode,
  output logic              clr_fire,
  output logic [FCNT_W-1:0] fcnt
);
  logic [FCNT_W-1:0] mask;
  logic [FCNT_W-1:0] fcnt_n;

  always_comb begin
    case (clr_mode_e'(mode))
      CLR_EVERY2: mask = 3'b001;
      CLR_EVERY4: mask = 3'b011;
      CLR_EVERY8: mask = 3'b111;
      default:    mask = 3'b000;
    endcase
    clr_fire = field_start && (clr_mode_e'(mode) != CLR_NEVER) && ((fcnt & mask) == mask);
    fcnt_n   = field_start ? fcnt + 1'b1 : fcnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fcnt <= '0;
    else        fcnt <= fcnt_n;
  end
endmodule

// File: rtl/sc_phase_gen.sv
module sc_phase_gen #(
  parameter int COARSE_W = 12,
  parameter int FINE_W   = 15,
  parameter int PHASE_W  = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pix_en,
  input  logic                field_start,
  input  logic [1:0]          clr_mode,
  input  logic                coarse_en,
  input  logic                mid_en,
  input  logic                fine_en,
  input  logic [COARSE_W-1:0] coarse_inc,
  input  logic [FINE_W-1:0]   mid_inc,
  input  logic [FINE_W-1:0]   mid_mod,
  input  logic [FINE_W-1:0]   fine_inc,
  input  logic [FINE_W-1:0]   fine_mod,
  output logic [PHASE_W-1:0]  phase_out
);
  import sc_phase_pkg::*;

  localparam int PHASE_LSB = COARSE_W - PHASE_W;

  logic                rst_meta, rst_sync_n;
  logic                clr_fire;
  logic [FCNT_W-1:0]   fcnt;
  logic                carry_fine, carry_mid;
  logic [FINE_W-1:0]   fine_acc, mid_acc;
  logic [COARSE_W-1:0] coarse_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  sc_field_sched u_sched (
    .clk(clk), .rst_n(rst_sync_n), .field_start(field_start), .mode(clr_mode),
    .clr_fire(clr_fire), .fcnt(fcnt)
  );

  sc_mod_dda #(.W(FINE_W)) u_fine (
    .clk(clk), .rst_n(rst_sync_n), .adv(pix_en), .clr(clr_fire), .en(fine_en),
    .inc(fine_inc), .modulus(fine_mod), .cin(1'b0), .acc(fine_acc), .cout(carry_fine)
  );

  sc_mod_dda #(.W(FINE_W)) u_mid (
    .clk(clk), .rst_n(rst_sync_n), .adv(pix_en), .clr(clr_fire), .en(mid_en),
    .inc(mid_inc), .modulus(mid_mod), .cin(carry_fine), .acc(mid_acc), .cout(carry_mid)
  );

  sc_wrap_acc #(.W(COARSE_W)) u_coarse (
    .clk(clk), .rst_n(rst_sync_n), .adv(pix_en), .clr(clr_fire), .en(coarse_en),
    .inc(coarse_inc), .cin(carry_mid), .acc(coarse_acc)
  );

  assign phase_out = coarse_acc[COARSE_W-1:PHASE_LSB];
endmodule

// File: rtl/sc_phase_chk.sv
module sc_phase_chk #(
  parameter int COARSE_W = 12,
  parameter int FINE_W   = 15
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pix_en,
  input logic                field_start,
  input logic [1:0]          clr_mode,
  input logic                coarse_en,
  input logic                clr_fire,
  input logic [2:0]          fcnt,
  input logic [COARSE_W-1:0] coarse_acc,
  input logic [FINE_W-1:0]   mid_acc,
  input logic [FINE_W-1:0]   fine_acc
);
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_en && !clr_fire) |=> ($stable(coarse_acc) && $stable(mid_acc) && $stable(fine_acc)));

  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> (coarse_acc == '0 && mid_acc == '0 && fine_acc == '0));

  p_coarse_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!coarse_en && !clr_fire) |=> $stable(coarse_acc));

  p_never_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mode == 2'd3) |-> !clr_fire);

  p_field_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> (fcnt == $past(fcnt) + 3'd1));

  p_clear_on_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |-> field_start);
endmodule

bind sc_phase_gen sc_phase_chk #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .pix_en(pix_en), .field_start(field_start),
  .clr_mode(clr_mode), .coarse_en(coarse_en), .clr_fire(clr_fire), .fcnt(fcnt),
  .coarse_acc(coarse_acc), .mid_acc(mid_acc), .fine_acc(fine_acc)
);

// File: tb/sim_sc_phase_gen.sv
`timescale 1ns/1ps
module sim_sc_phase_gen;
  localparam int PW = 10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, pix_en, field_start, coarse_en, mid_en, fine_en;
  logic [1:0]    clr_mode;
  logic [11:0]   coarse_inc;
  logic [14:0]   mid_inc, mid_mod, fine_inc, fine_mod;
  logic [PW-1:0] phase_out;

  sc_phase_gen #(.PHASE_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .field_start(field_start),
    .clr_mode(clr_mode), .coarse_en(coarse_en), .mid_en(mid_en), .fine_en(fine_en),
    .coarse_inc(coarse_inc), .mid_inc(mid_inc), .mid_mod(mid_mod),
    .fine_inc(fine_inc), .fine_mod(fine_mod), .phase_out(phase_out)
  );

  int    n_chk = 0, n_fail = 0;
  string tag = "R1";
  int    m1 = 0, m2 = 0, m3 = 0, mf = 0;
  bit    done = 0;

  task automatic check_val(input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: phase_out=%0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_update(input bit pe, input bit fs);
    int mask, s, c3, c2;
    case (clr_mode)
      2'd0: mask = 1;
      2'd1: mask = 3;
      2'd2: mask = 7;
      default: mask = 0;
    endcase
    if (fs && clr_mode != 2'd3 && ((mf & mask) == mask)) begin
      m1 = 0; m2 = 0; m3 = 0;
    end else if (pe) begin
      c3 = 0; c2 = 0;
      if (fine_en) begin
        s = m3 + int'(fine_inc);
        if (s >= int'(fine_mod)) begin m3 = (s - int'(fine_mod)) & 32767; c3 = 1; end
        else m3 = s;
      end
      if (mid_en) begin
        s = m2 + int'(mid_inc) + c3;
        if (s >= int'(mid_mod)) begin m2 = (s - int'(mid_mod)) & 32767; c2 = 1; end
        else m2 = s;
      end
      if (coarse_en) m1 = (m1 + int'(coarse_inc) + c2) & 4095;
    end
    if (fs) mf = (mf + 1) & 7;
  endtask

  task automatic step(input bit pe, input bit fs);
    @(negedge clk);
    pix_en = pe; field_start = fs;
    @(posedge clk);
    model_update(pe, fs);
    #1;
    check_val(int'(phase_out), m1 >> (12 - PW));
  endtask

  task automatic set_cfg(input bit e1, input bit e2, input bit e3, input int i1,
                         input int i2, input int s2, input int i3, input int s3);
    coarse_en = e1; mid_en = e2; fine_en = e3;
    coarse_inc = 12'(i1); mid_inc = 15'(i2); mid_mod = 15'(s2);
    fine_inc = 15'(i3); fine_mod = 15'(s3);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pix_en = 0; field_start = 0; clr_mode = 2'd3;
    set_cfg(1, 1, 1, 0, 0, 5, 3, 7);
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    tag = "R1"; check_val(int'(phase_out), 0);
    for (int j = 0; j < 3; j++) step(0, 0);

    // R2 / R3: closed form, fine 3/7 carries accumulate in a mod-5 middle stage
    tag = "R2";
    for (int j = 0; j < 140; j++) step(1, 0);
    tag = "R3"; check_val(int'(phase_out), ((140 * 3 / 7) / 5) >> (12 - PW));

    // R4: coarse wraps modulo 4096, output is upper bits
    tag = "R4"; set_cfg(1, 0, 0, 1000, 0, 5, 0, 7);
    for (int j = 0; j < 40; j++) step(1, 0);

    // R5: each stage disabled in turn
    tag = "R5"; set_cfg(0, 1, 1, 300, 9, 10, 5, 6);
    for (int j = 0; j < 30; j++) step(1, 0);
    set_cfg(1, 1, 0, 16, 9, 10, 5, 6);
    for (int j = 0; j < 30; j++) step(1, 0);
    set_cfg(1, 0, 1, 16, 9, 10, 5, 6);
    for (int j = 0; j < 30; j++) step(1, 0);

    // R6: idle pixels hold
    tag = "R6"; set_cfg(1, 1, 1, 77, 9, 10, 5, 6);
    for (int j = 0; j < 20; j++) step(0, 0);
    step(1, 0);

    // R9: clear in a cycle that also advances
    tag = "R9"; clr_mode = 2'd0;
    step(1, 1); step(1, 0); step(1, 1);
    check_val(int'(phase_out), 0);
    step(1, 0);

    // R7 / R8: sweep all clear modes over several configurations
    for (int md = 0; md < 4; md++) begin
      clr_mode = 2'(md);
      tag = (md == 3) ? "R8" : "R7";
      for (int k = 0; k < 3; k++) begin
        case (k)
          0: set_cfg(1, 1, 1, 37, 11, 13, 5, 9);
          1: set_cfg(1, 1, 1, 4000, 29000, 30000, 1, 2);
          default: set_cfg(1, 1, 1, 3, 7, 7, 4, 5);
        endcase
        for (int j = 0; j < 96; j++) step((j % 5) != 4, (j % 6) == 5);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule